// File: doc/BRIEF.md
# Trigger-Matched Binary Hit Sampler

This block sits behind a bank of binary discriminator outputs. It captures the whole channel vector on every clock into a circular history memory. A level-one trigger arrives a fixed time after the physics event. When it does, the block looks back into that history by a programmable latency and walks a window of consecutive samples. It turns every set bit it finds into a sparse record that holds the channel number and the position of the sample inside the window.

Triggers can come close together, so each accepted trigger stores its window start and length in a short queue. The scanner then serves the queued events one at a time, in arrival order. Records leave on a valid/ready stream. The first beat of each event carries a start marker. Each event closes with a single end beat, so an event with no hits still shows up downstream as exactly one beat.

Two error flags are provided. A configuration check flags latency and window settings that the history memory cannot serve. A sticky flag records that a trigger was lost because the queue was full.

Top module: `trig_hit_sampler`

## Requirements
- R1: On every clock edge out of reset, `chan_in` is written into the history slot at the write pointer. The write pointer starts at 0 after reset, advances by one per edge, and wraps modulo `DEPTH` (`DEPTH` is a power of two).
- R2: A trigger sampled high at edge n, with latency L and window W, selects the W samples captured at edges n-L through n-L+W-1. Window sample index k refers to the sample captured at edge n-L+k.
- R3: Each set bit in the window produces one hit beat with `rec_hit`=1, `rec_chan` set to the channel index and `rec_sample` set to k. Beats come in ascending k, and within one sample in ascending channel index.
- R4: Every event ends with exactly one end beat that has `rec_eof`=1, `rec_hit`=0 and zero channel and sample fields. Only the first beat of an event has `rec_sof`=1.
- R5: A window with no set bits produces an event made of a single beat with `rec_sof`=1, `rec_eof`=1 and `rec_hit`=0.
- R6: While `rec_valid` is high and `rec_ready` is low, `rec_valid` and all record fields hold their values.
- R7: Triggers that arrive while an earlier event is being scanned are queued, up to `QDEPTH` pending starts. Their events are emitted in trigger order.
- R8: A trigger that arrives when the queue is full and no entry leaves in the same cycle is dropped. In that case `ovf_err` goes high and stays high until reset.
- R9: `cfg_err` is high, combinationally, when the window is 0, when the window is larger than the latency, or when latency plus window is at least `DEPTH`. Triggers are ignored while it is high.
- R10: During and right after reset, `rec_valid` and `ovf_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_in | input | NCH | Discriminator levels, one bit per channel |
| trig_in | input | 1 | Fixed-latency trigger, one cycle per request |
| cfg_latency | input | $clog2(DEPTH) | Look-back in samples from trigger to window start |
| cfg_window | input | $clog2(DEPTH) | Window length in samples |
| rec_valid | output | 1 | Record beat available |
| rec_ready | input | 1 | Downstream accepts the beat |
| rec_chan | output | $clog2(NCH) | Channel index of a hit |
| rec_sample | output | $clog2(DEPTH) | Sample index within the window |
| rec_hit | output | 1 | Beat is a hit record |
| rec_sof | output | 1 | First beat of an event |
| rec_eof | output | 1 | End beat of an event |
| cfg_err | output | 1 | Latency/window setting unusable |
| ovf_err | output | 1 | Sticky: a trigger was dropped |

## Verification
The bench keeps its own copy of every captured sample and derives each event's expected beat list from the trigger edge. A scanner that is off by one in latency or window start therefore produces the wrong channel/sample pairs on random data. A run of several set bits in one sample word exposes a scanner that emits them out of channel order or skips a sample after a dense word. An all-zero window catches a design that emits nothing, or one that emits an end beat without the start marker. Two further cases target the queue and the edge of the legal range. Three triggers on consecutive cycles, and a burst under back-pressure that is one trigger larger than the queue, catch lost, duplicated or reordered events and an overflow flag that is missing or not sticky. A window placed right against the largest legal latency, together with rejected settings, catches a wrong bound in the configuration check.

// File: rtl/hs_pkg.sv
package hs_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SCAN = 2'd1,
      ST_END  = 2'd2
   } scan_st_t;
endpackage

// File: rtl/hs_history.sv
module hs_history #(
   parameter int NCH   = 128,
   parameter int DEPTH = 256,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] din,
   input  logic [AW-1:0]  raddr,
   output logic [NCH-1:0] rdata,
   output logic [AW-1:0]  wptr
);
   logic [NCH-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) wptr <= '0;
      else        wptr <= wptr + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst_n) store[wptr] <= din;
   end

   assign rdata = store[raddr];

   // R1: write pointer steps by one every cycle and wraps naturally
   a_r1_wptr_step: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> wptr == $past(wptr) + 1'b1);
endmodule

// File: rtl/hs_start_fifo.sv
module hs_start_fifo #(
   parameter int DW = 16,
   parameter int QD = 4,
   localparam int QAW = $clog2(QD)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [DW-1:0] push_data,
   input  logic          pop,
   output logic [DW-1:0] head,
   output logic          empty,
   output logic          drop
);
   logic [DW-1:0] slot [QD];
   logic [QAW-1:0] rp, wp;
   logic [QAW:0]   cnt;
   logic           full, accept;

   assign empty  = (cnt == '0);
   assign full   = (cnt == (QAW+1)'(QD));
   assign accept = push && (!full || pop);
   assign drop   = push && !accept;
   assign head   = slot[rp];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rp  <= '0;
         wp  <= '0;
         cnt <= '0;
      end else begin
         if (accept) wp <= wp + 1'b1;
         if (pop)    rp <= rp + 1'b1;
         case ({accept, pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (accept) slot[wp] <= push_data;
   end

   // R7: the scanner never takes a start from an empty queue
   a_r7_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
   // R7: occupancy never exceeds the queue depth
   a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= (QAW+1)'(QD));
endmodule

// File: rtl/hs_lsb_enc.sv
module hs_lsb_enc #(
   parameter int N = 128,
   localparam int CW = $clog2(N)
) (
   input  logic [N-1:0]  vec,
   output logic [CW-1:0] idx
);
   logic [N-1:0] below;
   logic [N-1:0] pick;

   assign below[0] = 1'b0;
   genvar gi;
   generate
      for (gi = 1; gi < N; gi++) begin : g_prefix
         assign below[gi] = below[gi-1] | vec[gi-1];
      end
   endgenerate

   assign pick = vec & ~below;

   always_comb begin
      idx = '0;
      for (int i = 0; i < N; i++) begin
         if (pick[i]) idx = CW'(i);
      end
   end
endmodule

// File: rtl/trig_hit_sampler.sv
module trig_hit_sampler
   import hs_pkg::*;
#(
   parameter int NCH    = 128,
   parameter int DEPTH  = 256,
   parameter int QDEPTH = 4,
   localparam int AW    = $clog2(DEPTH),
   localparam int CW    = $clog2(NCH),
   localparam int QW    = 2 * AW
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] chan_in,
   input  logic           trig_in,
   input  logic [AW-1:0]  cfg_latency,
   input  logic [AW-1:0]  cfg_window,
   output logic           rec_valid,
   input  logic           rec_ready,
   output logic [CW-1:0]  rec_chan,
   output logic [AW-1:0]  rec_sample,
   output logic           rec_hit,
   output logic           rec_sof,
   output logic           rec_eof,
   output logic           cfg_err,
   output logic           ovf_err
);
   generate
      if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 4) begin : g_bad_depth
         $error("DEPTH must be a power of two of at least 4");
      end
      if ((QDEPTH & (QDEPTH - 1)) != 0 || QDEPTH < 2) begin : g_bad_qdepth
         $error("QDEPTH must be a power of two of at least 2");
      end
      if (NCH < 2) begin : g_bad_nch
         $error("NCH must be at least 2");
      end
   endgenerate

   logic [AW-1:0]  wptr, raddr, addr, sidx, wlen;
   logic [NCH-1:0] rdata, cur;
   logic [CW-1:0]  low_idx;
   logic [AW:0]    span;
   logic [QW-1:0]  q_head;
   logic           q_empty, q_drop, q_push, q_pop, first;
   scan_st_t       st;

   // configuration check
   assign span    = {1'b0, cfg_latency} + {1'b0, cfg_window};
   assign cfg_err = (cfg_window == '0) || (cfg_window > cfg_latency)
                    || (span >= (AW+1)'(DEPTH));

   hs_history #(.NCH(NCH), .DEPTH(DEPTH)) u_hist (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (chan_in),
      .raddr (raddr),
      .rdata (rdata),
      .wptr  (wptr)
   );

   assign q_push = trig_in && !cfg_err;
   assign q_pop  = (st == ST_IDLE) && !q_empty;

   hs_start_fifo #(.DW(QW), .QD(QDEPTH)) u_queue (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (q_push),
      .push_data ({cfg_window, wptr - cfg_latency}),
      .pop       (q_pop),
      .head      (q_head),
      .empty     (q_empty),
      .drop      (q_drop)
   );

   hs_lsb_enc #(.N(NCH)) u_enc (
      .vec (cur),
      .idx (low_idx)
   );

   assign raddr = (st == ST_IDLE) ? q_head[AW-1:0] : addr + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         cur     <= '0;
         addr    <= '0;
         sidx    <= '0;
         wlen    <= '0;
         first   <= 1'b0;
         ovf_err <= 1'b0;
      end else begin
         if (q_drop) ovf_err <= 1'b1;
         case (st)
            ST_IDLE: begin
               if (!q_empty) begin
                  addr  <= q_head[AW-1:0];
                  wlen  <= q_head[QW-1:AW];
                  cur   <= rdata;
                  sidx  <= '0;
                  first <= 1'b1;
                  st    <= ST_SCAN;
               end
            end
            ST_SCAN: begin
               if (cur == '0) begin
                  if (sidx == wlen - 1'b1) begin
                     st <= ST_END;
                  end else begin
                     addr <= addr + 1'b1;
                     cur  <= rdata;
                     sidx <= sidx + 1'b1;
                  end
               end else if (rec_ready) begin
                  cur   <= cur & (cur - 1'b1);
                  first <= 1'b0;
               end
            end
            ST_END: begin
               if (rec_ready) st <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign rec_valid  = ((st == ST_SCAN) && (cur != '0)) || (st == ST_END);
   assign rec_hit    = (st == ST_SCAN);
   assign rec_eof    = (st == ST_END);
   assign rec_sof    = first;
   assign rec_chan   = (st == ST_SCAN) ? low_idx : '0;
   assign rec_sample = (st == ST_SCAN) ? sidx : '0;

   // R6: a stalled beat keeps its contents
   a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      rec_valid && !rec_ready |=> rec_valid && $stable(rec_chan)
      && $stable(rec_sample) && $stable(rec_hit) && $stable(rec_sof) && $stable(rec_eof));
   // R8: overflow flag is sticky
   a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_err |=> ovf_err);
   // R3: consecutive hit beats within an event ascend by sample, then channel
   a_r3_ascending: assert property (@(posedge clk) disable iff (!rst_n)
      rec_valid && rec_hit && !rec_sof && $past(rec_valid && rec_ready && rec_hit)
      |-> (rec_sample > $past(rec_sample))
          || ((rec_sample == $past(rec_sample)) && (rec_chan > $past(rec_chan))));
   // R4: the beat that follows an accepted end beat opens a new event
   a_r4_sof_after_eof: assert property (@(posedge clk) disable iff (!rst_n)
      rec_valid && rec_ready && rec_eof |=> !rec_valid || rec_sof);
endmodule

// File: tb/sim_trig_hit_sampler.sv
module sim_trig_hit_sampler;
   localparam int NCH = 16;
   localparam int DEPTH = 64;
   localparam int QD = 4;
   localparam int AW = $clog2(DEPTH);
   localparam int CW = $clog2(NCH);
   localparam int SZ = 4096;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NCH-1:0] chan_in = '0;
   logic trig_in = 1'b0;
   logic [AW-1:0] cfg_latency = AW'(20);
   logic [AW-1:0] cfg_window = AW'(6);
   logic rec_valid, rec_ready, rec_hit, rec_sof, rec_eof, cfg_err, ovf_err;
   logic [CW-1:0] rec_chan;
   logic [AW-1:0] rec_sample;

   always #5 clk = ~clk;

   trig_hit_sampler #(.NCH(NCH), .DEPTH(DEPTH), .QDEPTH(QD)) u0 (
      .clk(clk), .rst_n(rst_n), .chan_in(chan_in), .trig_in(trig_in),
      .cfg_latency(cfg_latency), .cfg_window(cfg_window),
      .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_chan(rec_chan),
      .rec_sample(rec_sample), .rec_hit(rec_hit), .rec_sof(rec_sof),
      .rec_eof(rec_eof), .cfg_err(cfg_err), .ovf_err(ovf_err)
   );

   int n_chk = 0, n_bad = 0, cyc = 0, beats = 0, eofs = 0, ecnt = 0, bp_cnt = 0;
   logic [NCH-1:0] captured [SZ];
   logic [31:0] expq [$];
   logic [31:0] s = 32'h1234_5678;
   logic [NCH-1:0] dens = '1;
   logic gen_on = 1'b1, model_on = 1'b1, bp_on = 1'b0;
   initial rec_ready = 1'b1;

   function automatic logic [31:0] pack(logic h, logic so, logic eo, int ch, int sm);
      return {13'd0, h, so, eo, 8'(ch), 8'(sm)};
   endfunction

   function automatic logic cfg_ok();
      int l = int'(cfg_latency), w = int'(cfg_window);
      return (w != 0) && (w <= l) && (l + w < DEPTH);
   endfunction

   task automatic chk(logic ok, string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // stimulus generator and back-pressure driver
   always @(negedge clk) begin
      s = s ^ (s << 13);
      s = s ^ (s >> 17);
      s = s ^ (s << 5);
      if (gen_on) chan_in = NCH'(s) & NCH'(s >> 11) & NCH'(s >> 19) & dens;
      if (bp_on) begin
         rec_ready = (bp_cnt % 3) != 0;
         bp_cnt++;
      end
   end

   // reference model: capture history (R1) and build events on triggers (R2..R5)
   always @(posedge clk) begin
      if (!rst_n) begin
         ecnt <= 0;
      end else begin
         if (trig_in && model_on && cfg_ok()) begin
            automatic int l = int'(cfg_latency);
            automatic int w = int'(cfg_window);
            automatic logic fst = 1'b1;
            for (int k = 0; k < w; k++) begin
               automatic logic [NCH-1:0] v = captured[(ecnt - l + k) & (SZ-1)];
               for (int c = 0; c < NCH; c++) begin
                  if (v[c]) begin
                     expq.push_back(pack(1'b1, fst, 1'b0, c, k));
                     fst = 1'b0;
                  end
               end
            end
            expq.push_back(pack(1'b0, fst, 1'b1, 0, 0));
         end
         captured[ecnt & (SZ-1)] <= chan_in;
         ecnt <= ecnt + 1;
      end
   end

   // output monitor
   always @(negedge clk) begin
      #1;
      if (rst_n && rec_valid && rec_ready) begin
         automatic logic [31:0] act = pack(rec_hit, rec_sof, rec_eof, int'(rec_chan), int'(rec_sample));
         beats++;
         if (rec_eof) eofs++;
         if (model_on) begin
            if (expq.size() == 0) chk(1'b0, "R9/R4 unexpected beat", act, 32'h0);
            else begin
               automatic logic [31:0] exp = expq.pop_front();
               chk(act == exp, "R2 R3 R4 R5 record", act, exp);
            end
         end
      end
   end

   task automatic summary_and_end();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual %0d expected below 100000", cyc);
         summary_and_end();
      end
   end

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic fire(int n);
      @(negedge clk);
      trig_in = 1'b1;
      repeat (n) @(negedge clk);
      trig_in = 1'b0;
   endtask

   task automatic drain(string tag);
      for (int i = 0; i < 600; i++) begin
         @(negedge clk);
         if (expq.size() == 0 && !rec_valid) break;
      end
      idle(3);
      chk(expq.size() == 0 && !rec_valid, tag, 32'(expq.size()), 32'h0);
   endtask

   task automatic drive_and_fire(logic [NCH-1:0] a, logic [NCH-1:0] b, logic [NCH-1:0] c);
      int l = int'(cfg_latency), w = int'(cfg_window);
      gen_on = 1'b0;
      for (int k = 0; k < w; k++) begin
         @(negedge clk);
         chan_in = (k == 0) ? a : (k == w-1) ? c : b;
      end
      for (int k = 0; k < l - w; k++) begin
         @(negedge clk);
         chan_in = '0;
      end
      @(negedge clk);
      trig_in = 1'b1;
      @(negedge clk);
      trig_in = 1'b0;
   endtask

   task automatic t_reset();
      idle(2);
      chk(!rec_valid, "R10 valid in reset", 32'(rec_valid), 32'h0);
      chk(!ovf_err, "R10 ovf in reset", 32'(ovf_err), 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      idle(2);
      chk(!rec_valid && !ovf_err, "R10 after reset", {rec_valid, ovf_err}, 32'h0);
      chk(!cfg_err, "R9 legal config", 32'(cfg_err), 32'h0);
   endtask

   task automatic t_random();   // R1 R2 R3 R4 over random data after wrap
      gen_on = 1'b1; dens = '1;
      idle(150);
      fire(1);
      drain("R2 random window drained");
      idle(37);
      fire(1);
      drain("R2 second random window drained");
   endtask

   task automatic t_empty();    // R5
      int b0;
      gen_on = 1'b0; chan_in = '0;
      idle(40);
      b0 = beats;
      fire(1);
      drain("R5 empty event drained");
      chk(beats - b0 == 1, "R5 single beat", 32'(beats - b0), 32'd1);
   endtask

   task automatic t_dense();    // R3 ordering inside one word
      drive_and_fire(16'h8101, 16'h0810, 16'hFFFF);
      drain("R3 dense window drained");
   endtask

   task automatic t_queue();    // R7
      int e0;
      gen_on = 1'b1; dens = 16'h0F0F;
      idle(40);
      e0 = eofs;
      fire(3);
      drain("R7 queued events drained");
      chk(eofs - e0 == 3, "R7 three events", 32'(eofs - e0), 32'd3);
   endtask

   task automatic t_backpressure();   // R6
      gen_on = 1'b1; dens = '1;
      idle(30);
      bp_on = 1'b1;
      fire(1);
      drain("R6 stalled stream drained");
      bp_on = 1'b0;
      @(negedge clk);
      rec_ready = 1'b1;
   endtask

   task automatic t_boundary();  // R2 at largest legal look-back
      cfg_latency = AW'(57); cfg_window = AW'(6);
      @(negedge clk);
      chk(!cfg_err, "R9 L+W=DEPTH-1 legal", 32'(cfg_err), 32'h0);
      drive_and_fire(16'h0008, 16'h0000, 16'h8000);
      drain("R2 boundary window drained");
      cfg_latency = AW'(20); cfg_window = AW'(6);
   endtask

   task automatic t_cfg();       // R9
      int b0;
      cfg_window = AW'(0);
      @(negedge clk); #1;
      chk(cfg_err, "R9 zero window", 32'(cfg_err), 32'h1);
      cfg_latency = AW'(20); cfg_window = AW'(21);
      @(negedge clk); #1;
      chk(cfg_err, "R9 window above latency", 32'(cfg_err), 32'h1);
      cfg_latency = AW'(40); cfg_window = AW'(24);
      @(negedge clk); #1;
      chk(cfg_err, "R9 L+W=DEPTH", 32'(cfg_err), 32'h1);
      b0 = beats;
      gen_on = 1'b1; dens = '1;
      fire(1);
      idle(30);
      chk(beats == b0 && !rec_valid, "R9 trigger ignored", 32'(beats - b0), 32'h0);
      cfg_latency = AW'(39);
      @(negedge clk); #1;
      chk(!cfg_err, "R9 L+W=DEPTH-1", 32'(cfg_err), 32'h0);
      cfg_latency = AW'(20); cfg_window = AW'(6);
      idle(2);
   endtask

   task automatic t_overflow();  // R8 and R7
      int e0;
      model_on = 1'b0;
      gen_on = 1'b1; dens = '1;
      idle(30);
      e0 = eofs;
      @(negedge clk);
      rec_ready = 1'b0;
      fire(QD + 2);
      idle(3);
      chk(ovf_err, "R8 overflow flagged", 32'(ovf_err), 32'h1);
      rec_ready = 1'b1;
      idle(300);
      chk(eofs - e0 == QD + 1, "R8 one trigger dropped", 32'(eofs - e0), 32'(QD + 1));
      chk(ovf_err, "R8 flag sticky", 32'(ovf_err), 32'h1);
   endtask

   initial begin
      t_reset();
      t_random();
      t_empty();
      t_dense();
      t_queue();
      t_backpressure();
      t_boundary();
      t_cfg();
      t_overflow();
      summary_and_end();
   end
endmodule